// File: doc/BRIEF.md
# Greedy Collision-Vector Task Admission Controller

This controller decides, cycle by cycle, when a new task may enter a non-linear pipeline. Each stage of that pipeline is used by a task in a fixed pattern over several cycles. The pattern is given as a static occupancy table with one row per stage and one column per cycle after entry. At elaboration the controller finds every start-to-start distance that would put two tasks in one stage in the same cycle. It packs these distances into a collision vector.

A state register holds the combined restrictions of all tasks still in flight. The register shifts right by one position each cycle. When a task starts, the shifted value is ORed with the collision vector.

A waiting task is admitted at the first cycle its request meets a permitted distance, which gives greedy scheduling. Along with the start pulse, the controller drives one busy enable per stage. These enables follow the occupancy table for every task in flight.

Top module: `cvc_ctrl`

## Requirements
- R1: After reset, every stage busy output is 0 and the state is empty. A request in the first cycle after reset release is granted with start_o high in that same cycle.
- R2: start_o is high in a cycle only when req_i is high and, for every earlier start, the distance in cycles to it is not forbidden. With the default table the forbidden distances are 2, 4 and 6.
- R3: The forbidden distances come from the table alone. They are every gap between two used columns of one stage row. A second table with forbidden distances {1, 2, 5} (collision vector 10011, leftmost bit for distance 5) must admit a constantly requesting source every 3 cycles.
- R4: A distance equal to or larger than the table span is always permitted. After span-1 cycles without a start, the state is empty again, and a request is granted at once and then also at distance 1 (default table).
- R5: With the default table and a request held high, starts occur at cycles 0, 1, 8, 9, 16, 17, which is the greedy cycle of latencies (1, 7) with an average of 4.
- R6: For those six tasks, the first and last cycles in which any stage is busy span 24 cycles inclusive.
- R7: A start in cycle t drives stage s busy in cycle t+1+c whenever bit c of row s is 1. Row s is RTAB[s*SPAN +: SPAN], and bit 0 is the first cycle after the start. Default rows, stage 0 to 3: 7'h45, 7'h22, 7'h08, 7'h50.
- R8: No stage is ever claimed by two tasks in the same cycle.
- R9: A cycle without a request has no effect beyond the passage of one cycle. No start occurs, busy outputs keep following the tasks in flight, and a later request is judged only by the distances to earlier starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | A task is waiting to enter |
| start_o | output | 1 | Task admitted this cycle (acknowledges req_i) |
| stage_busy_o | output | NSTG | Per-stage busy enable, bit s for stage s |

## Verification
The bench builds two copies of the block. The first uses the default 4-stage, 7-column table with forbidden distances {2, 4, 6}. The second uses a 4-stage, 6-column table with forbidden distances {1, 2, 5}. The default build brings within reach the (1, 7) greedy cycle, the 24-cycle span of six tasks, the denial at distance 2 and the return to an empty state after a long idle gap. The second build shows that the collision vector follows the table and not a fixed interval, because its greedy cycle falls to a constant latency of 3.

// File: rtl/cvc_pkg.sv
package cvc_pkg;
  // default occupancy table: 4 stages, 7 columns, rows packed stage 0 lowest
  localparam int unsigned DEF_NSTG = 4;
  localparam int unsigned DEF_SPAN = 7;
  localparam logic [DEF_NSTG*DEF_SPAN-1:0] DEF_RTAB =
    {7'h50, 7'h08, 7'h22, 7'h45};
endpackage

// File: rtl/cvc_rst_sync.sv
module cvc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/cvc_state.sv
module cvc_state #(
  parameter int unsigned W = 6,
  parameter logic [W-1:0] CV = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic start_o
);
  localparam int unsigned CW = $clog2(W + 2);

  logic [W-1:0]  st_q, st_d;
  logic [CW-1:0] idle_q, idle_d;
  logic          st_en;

  assign start_o = req_i & ~st_q[0];
  assign st_en   = 1'b1;

  always_comb begin
    st_d = st_q >> 1;
    if (start_o) st_d = st_d | CV;
  end

  always_comb begin
    idle_d = idle_q;
    if (start_o)                 idle_d = '0;
    else if (idle_q != CW'(W))   idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      idle_q <= CW'(W);
    end else if (st_en) begin
      st_q   <= st_d;
      idle_q <= idle_d;
    end
  end

  // R2
  cv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> ((st_q & CV) == CV));

  // R9
  idle_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_o |=> ($countones(st_q) <= $countones($past(st_q))));

  // R4
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q == CW'(W)) |-> (st_q == '0));
endmodule

// File: rtl/cvc_stage_track.sv
module cvc_stage_track #(
  parameter int unsigned SPAN = 7,
  parameter logic [SPAN-1:0] ROW = '0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  logic [SPAN-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q >> 1;
    if (start_i) sh_d = sh_d | ROW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign busy_o = sh_q[0];

  // R8
  stage_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (((sh_q >> 1) & ROW) == '0));

  generate
    if (ROW[0]) begin : g_first
      // R7
      first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);
    end
  endgenerate
endmodule

// File: rtl/cvc_ctrl.sv
module cvc_ctrl #(
  parameter int unsigned NSTG = cvc_pkg::DEF_NSTG,
  parameter int unsigned SPAN = cvc_pkg::DEF_SPAN,
  parameter logic [NSTG*SPAN-1:0] RTAB = cvc_pkg::DEF_RTAB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  output logic            start_o,
  output logic [NSTG-1:0] stage_busy_o
);
  localparam int unsigned W = SPAN - 1;

  // bit d-1 set when start distance d puts two tasks in one stage
  function automatic logic [W-1:0] calc_cv();
    logic [W-1:0] v;
    v = '0;
    for (int s = 0; s < int'(NSTG); s++)
      for (int a = 0; a < int'(SPAN); a++)
        for (int b = a + 1; b < int'(SPAN); b++)
          if (RTAB[s*SPAN + a] && RTAB[s*SPAN + b]) v[b-a-1] = 1'b1;
    return v;
  endfunction

  localparam logic [W-1:0] CV = calc_cv();

  logic rst_q_n;

  cvc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cvc_state #(.W(W), .CV(CV)) u_state (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .req_i   (req_i),
    .start_o (start_o)
  );

  generate
    for (genvar s = 0; s < int'(NSTG); s++) begin : g_stage
      cvc_stage_track #(
        .SPAN (SPAN),
        .ROW  (RTAB[s*SPAN +: SPAN])
      ) u_trk (
        .clk     (clk),
        .rst_n   (rst_q_n),
        .start_i (start_o),
        .busy_o  (stage_busy_o[s])
      );
    end
  endgenerate

  // R2
  grant_req_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    start_o |-> req_i);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(rst_q_n) |-> (stage_busy_o == '0));
endmodule

// File: tb/sim_cvc_ctrl.sv
module sim_cvc_ctrl;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req0 = 1'b0, req1 = 1'b0;
  logic start0, start1;
  logic [3:0] busy0, busy1;

  int n_chk = 0, n_fail = 0;
  int cyc;
  int first_busy, last_busy;
  bit h0 [0:255];
  bit h1 [0:255];

  localparam logic [5:0] FB0 = 6'b101010;
  localparam logic [4:0] FB1 = 5'b10011;
  logic [6:0] tb0 [4] = '{7'h45, 7'h22, 7'h08, 7'h50};
  logic [5:0] tb1 [4] = '{6'h21, 6'h06, 6'h14, 6'h08};

  always #(TCLK/2) clk = ~clk;

  cvc_ctrl u0 (
    .clk (clk), .rst_n (rst_n), .req_i (req0),
    .start_o (start0), .stage_busy_o (busy0)
  );

  cvc_ctrl #(.NSTG(4), .SPAN(6),
             .RTAB({6'h08, 6'h14, 6'h06, 6'h21})) u1 (
    .clk (clk), .rst_n (rst_n), .req_i (req1),
    .start_o (start1), .stage_busy_o (busy1)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d act=%0d exp=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic bit allow0(int c);
    for (int t = 0; t < c; t++)
      if (h0[t] && (c - t) <= 6 && FB0[c-t-1]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit allow1(int c);
    for (int t = 0; t < c; t++)
      if (h1[t] && (c - t) <= 5 && FB1[c-t-1]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int use0(int c, int s);
    int n = 0;
    for (int t = 0; t < c; t++)
      if (h0[t] && (c - t - 1) < 7 && tb0[s][c-t-1]) n++;
    return n;
  endfunction

  function automatic int use1(int c, int s);
    int n = 0;
    for (int t = 0; t < c; t++)
      if (h1[t] && (c - t - 1) < 6 && tb1[s][c-t-1]) n++;
    return n;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req0 = 1'b0; req1 = 1'b0;
    for (int i = 0; i < 256; i++) begin h0[i] = 1'b0; h1[i] = 1'b0; end
    cyc = 0; first_busy = -1; last_busy = -1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  // one cycle: drive, compare with the model, record expected starts
  task automatic step(input bit r0, input bit r1);
    bit e0, e1;
    int n;
    @(negedge clk);
    req0 = r0; req1 = r1;
    #1;
    e0 = r0 && allow0(cyc);
    e1 = r1 && allow1(cyc);
    chk(start0 == e0, "R2 start default", int'(start0), int'(e0));
    chk(start1 == e1, "R3 start alt", int'(start1), int'(e1));
    for (int s = 0; s < 4; s++) begin
      n = use0(cyc, s);
      chk(n <= 1, "R8 clash default", n, 1);
      chk(busy0[s] == (n > 0), "R7 busy default", int'(busy0[s]), int'(n > 0));
      n = use1(cyc, s);
      chk(n <= 1, "R8 clash alt", n, 1);
      chk(busy1[s] == (n > 0), "R7 busy alt", int'(busy1[s]), int'(n > 0));
    end
    if (busy0 != 4'b0) begin
      if (first_busy < 0) first_busy = cyc;
      last_busy = cyc;
    end
    h0[cyc] = e0;
    h1[cyc] = e1;
    cyc++;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(busy0 == 4'b0, "R1 busy after reset", int'(busy0), 0);
    chk(busy1 == 4'b0, "R1 busy after reset alt", int'(busy1), 0);
    step(1'b1, 1'b1);
    chk(start0 == 1'b1, "R1 first request granted", int'(start0), 1);
    chk(start1 == 1'b1, "R1 first request granted alt", int'(start1), 1);
  endtask

  task automatic t_greedy();
    int got [6];
    int ns = 0;
    do_reset();
    for (int i = 0; i < 30; i++) begin
      step(ns < 6, 1'b0);
      if (start0 && ns < 6) begin got[ns] = cyc - 1; ns++; end
    end
    chk(ns == 6, "R5 start count", ns, 6);
    chk(got[0] == 0,  "R5 start 0", got[0], 0);
    chk(got[1] == 1,  "R5 start 1", got[1], 1);
    chk(got[2] == 8,  "R5 start 2", got[2], 8);
    chk(got[3] == 9,  "R5 start 3", got[3], 9);
    chk(got[4] == 16, "R5 start 4", got[4], 16);
    chk(got[5] == 17, "R5 start 5", got[5], 17);
    chk(last_busy - first_busy + 1 == 24, "R6 span", last_busy - first_busy + 1, 24);
  endtask

  task automatic t_forbidden_gap();
    do_reset();
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    chk(start0 == 1'b0, "R2 distance 2 denied", int'(start0), 0);
    step(1'b1, 1'b0);
    chk(start0 == 1'b1, "R2 distance 3 granted", int'(start0), 1);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
  endtask

  task automatic t_idle_return();
    do_reset();
    step(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b0);
      chk(start0 == 1'b0, "R9 no request no start", int'(start0), 0);
    end
    step(1'b1, 1'b0);
    chk(start0 == 1'b1, "R4 distance 7 granted", int'(start0), 1);
    step(1'b1, 1'b0);
    chk(start0 == 1'b1, "R4 state empty again, distance 1", int'(start0), 1);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
  endtask

  task automatic t_alt_config();
    int ns = 0;
    do_reset();
    for (int i = 0; i < 13; i++) begin
      step(1'b1, 1'b1);
      if (start1) begin
        chk((cyc - 1) % 3 == 0, "R3 alt latency 3", cyc - 1, 3 * ns);
        ns++;
      end
    end
    chk(ns == 5, "R3 alt start count", ns, 5);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_greedy();
    t_forbidden_gap();
    t_idle_return();
    t_alt_config();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule